// File: doc/BRIEF.md
# Serial Line Register Interface

This block is the host-side register and control logic of one asynchronous serial line. A host reaches it through a simple word bus. When address bits 12..3 match a strapped base value, the block answers and presents four word registers: receiver status, receiver buffer, transmitter status and transmitter buffer. Two small shifters inside the block send and receive the serial frames. Each frame is a start bit, 5 to 8 data bits sent LSB first, an optional parity bit and one stop bit.

Received characters are placed in the receiver buffer. Their error flags can optionally appear in its high byte. Receive and transmit events raise a single interrupt request, and the block supplies a vector taken from strap inputs. A bad stop bit on the line can also be turned into a system halt request, or into a pulse on a power-ok output that forces a reload. A maintenance loopback bit turns both of these actions off.

Top module: `sline_regif`

## Requirements
- R1: The block responds only when `bus_addr[12:3]` equals `cfg_base`. `bus_addr[2:1]` selects the register: 0 receiver status, 1 receiver buffer, 2 transmitter status, 3 transmitter buffer. A read that does not match returns 0 with `bus_sel` low, and a write that does not match changes nothing.
- R2: After reset, receiver status reads 0x0000, transmitter status reads 0x0080, and the outputs are `txd`=1, `irq_req`=0, `halt_req`=0, `pwr_ok`=1.
- R3: A received frame has the format set by `cfg_len` (00=5, 01=6, 10=7, 11=8 data bits), `cfg_par_en` and `cfg_par_odd`. Its data appears in receiver buffer bits 7:0, with unused upper data bits read as 0. Receiver status bit 7 (done) is set. Receiver status bit 6 is a writable interrupt enable.
- R4: Reading the receiver buffer clears done.
- R5: When `cfg_errflag_en`=1, the receiver buffer high byte holds the error flags of the latest character: bit 15 any error, bit 14 overrun, bit 13 framing error, bit 12 parity error. When `cfg_errflag_en`=0, bits 15:8 read 0. Parity is even when `cfg_par_odd`=0 and odd when it is 1.
- R6: A write to the transmitter buffer while ready (transmitter status bit 7) is 1 clears ready and sends one frame in the configured format, with the parity bit inserted. Ready returns to 1 after the stop bit. Writes made while ready is 0 are ignored.
- R7: An interrupt becomes pending when done&rxIE or ready&txIE (transmitter status bit 6) goes from 0 to 1. The vector is `{cfg_vec,3'b000}` for receive and `{cfg_vec,3'b100}` for transmit. Receive is served first. `irq_ack` clears the source whose vector is being presented.
- R8: Transmitter status bit 0 (send break) holds `txd` low. It can be set only while `cfg_brk_en`=1.
- R9: Transmitter status bit 2 (maintenance) can be set only while `cfg_maint_en`=1. When it is set, the transmit line feeds the receiver and `rxd` is ignored.
- R10: A received framing error gives a one-cycle `halt_req` pulse when `cfg_halt_en`=1 and maintenance is 0.
- R11: A received framing error or break drives `pwr_ok` low for BOOT_CYC cycles when `cfg_boot_en`=1 and maintenance is 0.
- R12: A character that arrives while done is still 1 sets the overrun flag and replaces the buffered data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Word address, bits 12..1 |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 16 | Write data |
| bus_sel | output | 1 | Address matches the base |
| bus_rdata | output | 16 | Read data, valid during bus_rd |
| irq_req | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq_vec | output | 9 | Vector of the presented source |
| cfg_base | input | 10 | Base address, bits 12..3 |
| cfg_vec | input | 6 | Vector bits 8..3 |
| cfg_len | input | 2 | Data length code |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_odd | input | 1 | Odd parity when 1 |
| cfg_brk_en | input | 1 | Allow send break |
| cfg_maint_en | input | 1 | Allow maintenance bit |
| cfg_halt_en | input | 1 | Halt on framing error |
| cfg_boot_en | input | 1 | Reload on framing error or break |
| cfg_errflag_en | input | 1 | Show error flags in the receiver buffer |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| halt_req | output | 1 | Halt request pulse |
| pwr_ok | output | 1 | Power-ok, pulled low to force a reload |

## Verification
The assertions assume three things about the inputs:
- the host never starts a frame while the transmitter is busy;
- `irq_ack` arrives only while a request is pending;
- the format straps stay fixed while a frame is on the line.

The bench respects each of these. It changes the straps only after the receiver and transmitter have gone idle. It pulses `irq_ack` only after it has seen `irq_req` high. It drives `rxd` a whole bit time per bit at negative edges, so the receiver always samples in the middle of a bit.

// File: rtl/sline_pkg.sv
package sline_pkg;
    localparam int WORD_W  = 16;
    localparam int CHAR_W  = 8;
    localparam int BASE_W  = 10;
    localparam int ADDR_HI = BASE_W + 2;
    localparam int VEC_W   = 6;
    localparam int FRAME_W = CHAR_W + 3;
    localparam int IDX_W   = $clog2(CHAR_W);

    typedef enum logic [1:0] {
        REG_RCS  = 2'd0,
        REG_RBUF = 2'd1,
        REG_XCS  = 2'd2,
        REG_XBUF = 2'd3
    } reg_sel_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_WAITH
    } rx_st_e;

    typedef struct packed {
        logic [1:0] len_code;
        logic       par_en;
        logic       par_odd;
    } fmt_t;

    function automatic logic [3:0] char_bits(input logic [1:0] code);
        return {2'b00, code} + 4'd5;
    endfunction

    function automatic logic [CHAR_W-1:0] mask_char(input logic [CHAR_W-1:0] d,
                                                    input logic [1:0] code);
        logic [CHAR_W-1:0] m;
        for (int i = 0; i < CHAR_W; i++)
            m[i] = d[i] & (i < int'(char_bits(code)));
        return m;
    endfunction

    function automatic logic par_bit(input logic [CHAR_W-1:0] d,
                                     input logic [1:0] code, input logic odd);
        return (^mask_char(d, code)) ^ odd;
    endfunction

    function automatic logic [FRAME_W-1:0] build_frame(input logic [CHAR_W-1:0] d,
                                                       input fmt_t f);
        logic [FRAME_W-1:0] fr;
        int nb;
        fr = '1;
        fr[0] = 1'b0;
        nb = int'(char_bits(f.len_code));
        for (int i = 0; i < CHAR_W; i++)
            if (i < nb) fr[i+1] = d[i];
        if (f.par_en) fr[nb+1] = par_bit(d, f.len_code, f.par_odd);
        return fr;
    endfunction
endpackage

// File: rtl/sline_tx.sv
module sline_tx
    import sline_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CHAR_W-1:0] data_i,
    input  fmt_t              fmt_i,
    output logic              line_o,
    output logic              done_o
);
    localparam int CNT_W  = $clog2(CLKS_PER_BIT);
    localparam int LEFT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CLKS_PER_BIT - 1);

    typedef struct packed {
        logic               busy;
        logic [FRAME_W-1:0] sh;
        logic [CNT_W-1:0]   cnt;
        logic [LEFT_W-1:0]  left;
        logic               done;
    } tx_st_t;

    tx_st_t q, d;

    always_comb begin
        d = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (start_i) begin
                d.busy = 1'b1;
                d.sh   = build_frame(data_i, fmt_i);
                d.cnt  = CNT_TOP;
                d.left = LEFT_W'(char_bits(fmt_i.len_code)) + LEFT_W'(fmt_i.par_en) + LEFT_W'(1);
            end
        end else if (q.cnt != '0) begin
            d.cnt = q.cnt - 1'b1;
        end else if (q.left == '0) begin
            d.busy = 1'b0;
            d.done = 1'b1;
            d.sh   = '1;
        end else begin
            d.sh   = {1'b1, q.sh[FRAME_W-1:1]};
            d.left = q.left - 1'b1;
            d.cnt  = CNT_TOP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.busy <= 1'b0;
            q.sh   <= '1;
            q.cnt  <= '0;
            q.left <= '0;
            q.done <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign line_o = q.sh[0];
    assign done_o = q.done;

    // R6
    tx_start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !q.busy);
    // R6
    tx_done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.busy && !q.done);
endmodule

// File: rtl/sline_rx.sv
module sline_rx
    import sline_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_i,
    input  fmt_t              fmt_i,
    output logic              valid_o,
    output logic [CHAR_W-1:0] data_o,
    output logic              fe_o,
    output logic              pe_o,
    output logic              brk_o
);
    localparam int CNT_W = $clog2(CLKS_PER_BIT);
    localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(CLKS_PER_BIT - 1);
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(CLKS_PER_BIT / 2 - 1);

    typedef struct packed {
        rx_st_e            st;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [CHAR_W-1:0] data;
        logic              parb;
        logic              valid;
        logic              fe;
        logic              pe;
        logic              brk;
    } rx_state_t;

    rx_state_t q, d;

    always_comb begin
        d = q;
        d.valid = 1'b0;
        if (q.st == RX_IDLE) begin
            if (!line_i) begin
                d.st  = RX_START;
                d.cnt = CNT_HALF;
            end
        end else if (q.st == RX_WAITH) begin
            if (line_i) d.st = RX_IDLE;
        end else if (q.cnt != '0) begin
            d.cnt = q.cnt - 1'b1;
        end else begin
            d.cnt = CNT_TOP;
            case (q.st)
                RX_START: begin
                    if (!line_i) begin
                        d.st   = RX_DATA;
                        d.idx  = '0;
                        d.data = '0;
                    end else begin
                        d.st = RX_IDLE;
                    end
                end
                RX_DATA: begin
                    d.data[q.idx] = line_i;
                    if (4'(q.idx) == char_bits(fmt_i.len_code) - 4'd1)
                        d.st = fmt_i.par_en ? RX_PAR : RX_STOP;
                    else
                        d.idx = q.idx + 1'b1;
                end
                RX_PAR: begin
                    d.parb = line_i;
                    d.st   = RX_STOP;
                end
                RX_STOP: begin
                    d.valid = 1'b1;
                    d.fe    = !line_i;
                    d.pe    = fmt_i.par_en &&
                              (q.parb != par_bit(q.data, fmt_i.len_code, fmt_i.par_odd));
                    d.brk   = !line_i && (q.data == '0) && !(fmt_i.par_en && q.parb);
                    d.st    = line_i ? RX_IDLE : RX_WAITH;
                end
                default: d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= RX_IDLE;
            q.cnt   <= '0;
            q.idx   <= '0;
            q.data  <= '0;
            q.parb  <= 1'b0;
            q.valid <= 1'b0;
            q.fe    <= 1'b0;
            q.pe    <= 1'b0;
            q.brk   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign valid_o = q.valid;
    assign data_o  = q.data;
    assign fe_o    = q.fe;
    assign pe_o    = q.pe;
    assign brk_o   = q.brk;

    // R3
    rx_valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid |=> !q.valid);
    // R11
    rx_brk_is_fe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.valid && q.brk) |-> q.fe);
endmodule

// File: rtl/sline_irq.sv
module sline_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_cond_i,
    input  logic tx_cond_i,
    input  logic ack_i,
    output logic req_o,
    output logic tx_sel_o
);
    typedef struct packed {
        logic rx_prev;
        logic tx_prev;
        logic rx_pend;
        logic tx_pend;
    } irq_st_t;

    irq_st_t q, d;

    always_comb begin
        d = q;
        d.rx_prev = rx_cond_i;
        d.tx_prev = tx_cond_i;
        if (rx_cond_i && !q.rx_prev)
            d.rx_pend = 1'b1;
        else if (!rx_cond_i || (ack_i && q.rx_pend))
            d.rx_pend = 1'b0;
        if (tx_cond_i && !q.tx_prev)
            d.tx_pend = 1'b1;
        else if (!tx_cond_i || (ack_i && !q.rx_pend && q.tx_pend))
            d.tx_pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_o    = q.rx_pend | q.tx_pend;
    assign tx_sel_o = !q.rx_pend;

    // R7
    irq_ack_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && q.rx_pend) |=> !q.rx_pend);
    // R7
    irq_rx_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && q.rx_pend && q.tx_pend && tx_cond_i) |=> q.tx_pend);
    // R7
    irq_ack_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |-> req_o);
endmodule

// File: rtl/sline_regif.sv
module sline_regif
    import sline_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16,
    parameter int BOOT_CYC     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_HI:1]     bus_addr,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic                 bus_sel,
    output logic [WORD_W-1:0]    bus_rdata,
    output logic                 irq_req,
    input  logic                 irq_ack,
    output logic [VEC_W+2:0]     irq_vec,
    input  logic [BASE_W-1:0]    cfg_base,
    input  logic [VEC_W-1:0]     cfg_vec,
    input  logic [1:0]           cfg_len,
    input  logic                 cfg_par_en,
    input  logic                 cfg_par_odd,
    input  logic                 cfg_brk_en,
    input  logic                 cfg_maint_en,
    input  logic                 cfg_halt_en,
    input  logic                 cfg_boot_en,
    input  logic                 cfg_errflag_en,
    input  logic                 rxd,
    output logic                 txd,
    output logic                 halt_req,
    output logic                 pwr_ok
);
    localparam int BOOT_W = $clog2(BOOT_CYC + 1);

    typedef struct packed {
        logic              rx_ie;
        logic              rx_done;
        logic [CHAR_W-1:0] rx_data;
        logic              e_ovr;
        logic              e_fe;
        logic              e_pe;
        logic              tx_ie;
        logic              tx_ready;
        logic              maint;
        logic              brk;
        logic              halt;
        logic [BOOT_W-1:0] boot_cnt;
    } ctl_t;

    ctl_t q, d;

    fmt_t              fmt;
    reg_sel_e          rsel;
    logic              hit, rd_rbuf, tx_start, tx_line, tx_done, line_eff, rx_line;
    logic              rx_valid, rx_fe, rx_pe, rx_brk, tx_sel;
    logic [CHAR_W-1:0] rx_data;
    logic [7:0]        unused_wdata;

    assign unused_wdata = bus_wdata[15:8];
    assign fmt      = '{len_code: cfg_len, par_en: cfg_par_en, par_odd: cfg_par_odd};
    assign hit      = (bus_addr[ADDR_HI:3] == cfg_base);
    assign rsel     = reg_sel_e'(bus_addr[2:1]);
    assign rd_rbuf  = bus_rd && hit && (rsel == REG_RBUF);
    assign tx_start = bus_wr && hit && (rsel == REG_XBUF) && q.tx_ready;
    assign line_eff = q.brk ? 1'b0 : tx_line;
    assign rx_line  = q.maint ? line_eff : rxd;

    sline_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
        .clk(clk), .rst_n(rst_n), .start_i(tx_start), .data_i(bus_wdata[CHAR_W-1:0]),
        .fmt_i(fmt), .line_o(tx_line), .done_o(tx_done)
    );

    sline_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
        .clk(clk), .rst_n(rst_n), .line_i(rx_line), .fmt_i(fmt), .valid_o(rx_valid),
        .data_o(rx_data), .fe_o(rx_fe), .pe_o(rx_pe), .brk_o(rx_brk)
    );

    sline_irq u_irq (
        .clk(clk), .rst_n(rst_n), .rx_cond_i(q.rx_done && q.rx_ie),
        .tx_cond_i(q.tx_ready && q.tx_ie), .ack_i(irq_ack),
        .req_o(irq_req), .tx_sel_o(tx_sel)
    );

    always_comb begin
        d = q;
        d.halt = 1'b0;
        if (rx_valid) begin
            d.rx_data = rx_data;
            d.e_ovr   = q.rx_done;
            d.e_fe    = rx_fe;
            d.e_pe    = rx_pe;
            d.rx_done = 1'b1;
        end else if (rd_rbuf) begin
            d.rx_done = 1'b0;
        end
        if (bus_wr && hit && rsel == REG_RCS)
            d.rx_ie = bus_wdata[6];
        if (bus_wr && hit && rsel == REG_XCS) begin
            d.tx_ie = bus_wdata[6];
            d.maint = bus_wdata[2] && cfg_maint_en;
            d.brk   = bus_wdata[0] && cfg_brk_en;
        end
        if (tx_start)     d.tx_ready = 1'b0;
        else if (tx_done) d.tx_ready = 1'b1;
        d.halt = rx_valid && rx_fe && cfg_halt_en && !q.maint;
        if (rx_valid && (rx_fe || rx_brk) && cfg_boot_en && !q.maint)
            d.boot_cnt = BOOT_W'(BOOT_CYC);
        else if (q.boot_cnt != '0)
            d.boot_cnt = q.boot_cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.tx_ready <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd && hit) begin
            case (rsel)
                REG_RCS:  bus_rdata = {8'h00, q.rx_done, q.rx_ie, 6'b0};
                REG_RBUF: bus_rdata = {cfg_errflag_en ? {q.e_ovr | q.e_fe | q.e_pe,
                                       q.e_ovr, q.e_fe, q.e_pe} : 4'b0000, 4'b0000, q.rx_data};
                REG_XCS:  bus_rdata = {8'h00, q.tx_ready, q.tx_ie, 3'b000, q.maint, 1'b0, q.brk};
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign bus_sel  = hit;
    assign irq_vec  = {cfg_vec, tx_sel, 2'b00};
    assign txd      = line_eff;
    assign halt_req = q.halt;
    assign pwr_ok   = (q.boot_cnt == '0);

    // R8
    brk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.brk) |-> $past(cfg_brk_en));
    // R9
    maint_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.maint) |-> $past(cfg_maint_en));
    // R10
    halt_maint_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.halt |-> (!$past(q.maint) && $past(cfg_halt_en)));
    // R4
    rbuf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rbuf && !rx_valid) |=> !q.rx_done);
    // R11
    boot_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_ok) |-> ($past(cfg_boot_en) && !$past(q.maint)));
    // R6
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !q.tx_ready);
endmodule

// File: tb/sline_regif_tb.sv
module sline_regif_tb;
    localparam int CPB  = 8;
    localparam int BOOT = 6;
    localparam logic [9:0] BASE = 10'h1F3;

    logic        clk = 0, rst_n = 0;
    logic [12:1] bus_addr = '0;
    logic        bus_rd = 0, bus_wr = 0, bus_sel, irq_req, irq_ack = 0;
    logic [15:0] bus_wdata = '0, bus_rdata;
    logic [8:0]  irq_vec;
    logic [9:0]  cfg_base = BASE;
    logic [5:0]  cfg_vec = 6'b101101;
    logic [1:0]  cfg_len = 2'b11;
    logic        cfg_par_en = 0, cfg_par_odd = 0, cfg_brk_en = 0, cfg_maint_en = 0;
    logic        cfg_halt_en = 0, cfg_boot_en = 0, cfg_errflag_en = 1;
    logic        rxd = 1, txd, halt_req, pwr_ok;

    int total = 0, bad = 0, halt_cnt = 0, low_cnt = 0;
    bit finished = 0;
    logic [15:0] rv;
    logic        rs;

    sline_regif #(.CLKS_PER_BIT(CPB), .BOOT_CYC(BOOT)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_sel(bus_sel), .bus_rdata(bus_rdata), .irq_req(irq_req),
        .irq_ack(irq_ack), .irq_vec(irq_vec), .cfg_base(cfg_base), .cfg_vec(cfg_vec),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_brk_en(cfg_brk_en), .cfg_maint_en(cfg_maint_en), .cfg_halt_en(cfg_halt_en),
        .cfg_boot_en(cfg_boot_en), .cfg_errflag_en(cfg_errflag_en), .rxd(rxd), .txd(txd),
        .halt_req(halt_req), .pwr_ok(pwr_ok)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (rst_n && halt_req) halt_cnt++;
        if (rst_n && !pwr_ok)  low_cnt++;
    end

    function automatic logic [7:0] m_mask(input logic [7:0] d, input logic [1:0] c);
        return d & 8'(8'hFF >> (3 - int'(c)));
    endfunction

    function automatic logic m_par(input logic [7:0] d, input logic [1:0] c, input logic odd);
        int ones = 0;
        for (int i = 0; i < 8; i++) if (i < int'(c) + 5 && d[i]) ones++;
        return (ones % 2 == 1) ^ odd;
    endfunction

    function automatic logic [15:0] m_rbuf(input logic [7:0] d, input logic [1:0] c,
                                           input bit ovr, input bit fe, input bit pe, input bit ef);
        if (!ef) return {8'h00, m_mask(d, c)};
        return {ovr | fe | pe, ovr, fe, pe, 4'h0, m_mask(d, c)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] r, input logic [9:0] base);
        @(negedge clk);
        bus_addr = {base, r}; bus_rd = 1;
        #1; rv = bus_rdata; rs = bus_sel;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic wr(input logic [1:0] r, input logic [15:0] v, input logic [9:0] base);
        @(negedge clk);
        bus_addr = {base, r}; bus_wdata = v; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic send_rx(input logic [7:0] d, input bit badpar, input bit stopb);
        @(negedge clk);
        rxd = 0; repeat (CPB) @(negedge clk);
        for (int i = 0; i < int'(cfg_len) + 5; i++) begin
            rxd = d[i]; repeat (CPB) @(negedge clk);
        end
        if (cfg_par_en) begin
            rxd = m_par(d, cfg_len, cfg_par_odd) ^ badpar; repeat (CPB) @(negedge clk);
        end
        rxd = stopb; repeat (CPB) @(negedge clk);
        rxd = 1; repeat (4) @(negedge clk);
    endtask

    task automatic check_tx(input logic [7:0] d, input string req);
        int guard = 0;
        logic [7:0] cap = '0;
        logic pb = 0, sb;
        while (txd !== 1'b0 && guard < 2000) begin @(negedge clk); guard++; end
        repeat (CPB/2) @(negedge clk);
        chk({req, " start bit"}, 32'(txd), 32'h0);
        for (int i = 0; i < int'(cfg_len) + 5; i++) begin
            repeat (CPB) @(negedge clk);
            cap[i] = txd;
        end
        if (cfg_par_en) begin repeat (CPB) @(negedge clk); pb = txd; end
        repeat (CPB) @(negedge clk);
        sb = txd;
        chk({req, " data"}, 32'(cap), 32'(m_mask(d, cfg_len)));
        if (cfg_par_en) chk({req, " parity"}, 32'(pb), 32'(m_par(d, cfg_len, cfg_par_odd)));
        chk({req, " stop bit"}, 32'(sb), 32'h1);
        repeat (CPB) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int h0, l0, lows;
        void'($urandom(32'd4711));
        repeat (5) @(negedge clk);
        rst_n = 1;

        // R2 reset state
        rd(0, BASE); chk("R2 rx status", 32'(rv), 32'h0000);
        rd(2, BASE); chk("R2 tx status", 32'(rv), 32'h0080);
        chk("R2 outputs", {28'h0, txd, irq_req, halt_req, pwr_ok}, 32'b1001);

        // R1 decode
        rd(0, BASE ^ 10'h004); chk("R1 miss select", 32'(rs), 32'h0);
        chk("R1 miss data", 32'(rv), 32'h0);
        rd(2, BASE); chk("R1 hit select", 32'(rs), 32'h1);
        wr(3, 16'h00A5, BASE ^ 10'h100);
        lows = 0;
        for (int i = 0; i < 3 * CPB; i++) begin @(negedge clk); if (!txd) lows++; end
        chk("R1 miss write no frame", 32'(lows), 32'h0);
        rd(2, BASE); chk("R1 miss write status", 32'(rv), 32'h0080);

        // R3 R4 R6 random formats
        for (int k = 0; k < 10; k++) begin
            logic [7:0] dv;
            dv = 8'($urandom);
            cfg_len = 2'($urandom); cfg_par_en = 1'($urandom); cfg_par_odd = 1'($urandom);
            send_rx(dv, 0, 1);
            rd(0, BASE); chk("R3 done set", 32'(rv), 32'h0080);
            rd(1, BASE); chk("R3 rx data", 32'(rv), 32'(m_rbuf(dv, cfg_len, 0, 0, 0, 1)));
            rd(0, BASE); chk("R4 done cleared", 32'(rv), 32'h0000);
            dv = 8'($urandom);
            wr(3, {8'h00, dv}, BASE);
            rd(2, BASE); chk("R6 ready cleared", 32'(rv), 32'h0000);
            check_tx(dv, "R6 tx frame");
            rd(2, BASE); chk("R6 ready back", 32'(rv), 32'h0080);
        end

        // R5 parity error, 8 bits even
        cfg_len = 2'b11; cfg_par_en = 1; cfg_par_odd = 0;
        send_rx(8'h3C, 1, 1);
        rd(1, BASE); chk("R5 parity error", 32'(rv), 32'h903C);
        // R5 flags hidden
        cfg_errflag_en = 0;
        send_rx(8'h55, 1, 1);
        rd(1, BASE); chk("R5 flags disabled", 32'(rv), 32'h0055);
        cfg_errflag_en = 1; cfg_par_en = 0;
        // R5 framing error, no halt/boot enabled
        h0 = halt_cnt; l0 = low_cnt;
        send_rx(8'h41, 0, 0);
        rd(1, BASE); chk("R5 framing error", 32'(rv), 32'hA041);
        chk("R10 halt disabled", 32'(halt_cnt - h0), 32'h0);
        chk("R11 boot disabled", 32'(low_cnt - l0), 32'h0);
        // R12 overrun
        send_rx(8'h11, 0, 1);
        send_rx(8'h22, 0, 1);
        rd(1, BASE); chk("R12 overrun", 32'(rv), 32'hC022);

        // R6 write while busy ignored, 5-bit odd parity
        cfg_len = 2'b00; cfg_par_en = 1; cfg_par_odd = 1;
        wr(3, 16'h00FF, BASE);
        wr(3, 16'h0000, BASE);
        check_tx(8'hFF, "R6 first frame");
        lows = 0;
        for (int i = 0; i < 3 * CPB; i++) begin @(negedge clk); if (!txd) lows++; end
        chk("R6 busy write ignored", 32'(lows), 32'h0);
        rd(2, BASE); chk("R6 idle status", 32'(rv), 32'h0080);
        cfg_len = 2'b11; cfg_par_en = 0; cfg_par_odd = 0;

        // R8 break gating
        wr(2, 16'h0001, BASE);
        rd(2, BASE); chk("R8 break blocked", 32'(rv), 32'h0080);
        chk("R8 line idle", 32'(txd), 32'h1);
        cfg_brk_en = 1;
        wr(2, 16'h0001, BASE);
        rd(2, BASE); chk("R8 break set", 32'(rv), 32'h0081);
        chk("R8 line low", 32'(txd), 32'h0);
        wr(2, 16'h0000, BASE);
        chk("R8 line released", 32'(txd), 32'h1);

        // R9 maintenance gating and loopback
        wr(2, 16'h0004, BASE);
        rd(2, BASE); chk("R9 maint blocked", 32'(rv), 32'h0080);
        cfg_maint_en = 1;
        wr(2, 16'h0004, BASE);
        rd(2, BASE); chk("R9 maint set", 32'(rv), 32'h0084);
        rxd = 0;
        wr(3, 16'h005A, BASE);
        repeat (14 * CPB) @(negedge clk);
        rd(1, BASE); chk("R9 loopback data", 32'(rv), 32'h005A);
        // R10 R11 suppressed in maintenance
        cfg_halt_en = 1; cfg_boot_en = 1;
        h0 = halt_cnt; l0 = low_cnt;
        wr(2, 16'h0005, BASE);
        repeat (14 * CPB) @(negedge clk);
        wr(2, 16'h0004, BASE);
        repeat (2 * CPB) @(negedge clk);
        chk("R10 halt masked by maint", 32'(halt_cnt - h0), 32'h0);
        chk("R11 boot masked by maint", 32'(low_cnt - l0), 32'h0);
        rd(1, BASE); chk("R9 looped break flags", 32'(rv), 32'hA000);
        rxd = 1;
        @(negedge clk);
        wr(2, 16'h0000, BASE);

        // R10 R11 active
        h0 = halt_cnt; l0 = low_cnt;
        send_rx(8'h41, 0, 0);
        repeat (10) @(negedge clk);
        chk("R10 halt pulse", 32'(halt_cnt - h0), 32'h1);
        chk("R11 boot pulse width", 32'(low_cnt - l0), 32'(BOOT));
        rd(1, BASE);
        cfg_halt_en = 0;
        h0 = halt_cnt; l0 = low_cnt;
        send_rx(8'h00, 0, 0);
        repeat (10) @(negedge clk);
        chk("R11 break boot", 32'(low_cnt - l0), 32'(BOOT));
        chk("R10 no halt when off", 32'(halt_cnt - h0), 32'h0);
        rd(1, BASE);
        cfg_boot_en = 0;

        // R7 interrupts
        wr(0, 16'h0040, BASE);
        send_rx(8'h77, 0, 1);
        chk("R7 rx request", {23'h0, irq_req, irq_vec}, {23'h0, 1'b1, cfg_vec, 3'b000});
        wr(2, 16'h0040, BASE);
        chk("R7 rx priority", {23'h0, irq_req, irq_vec}, {23'h0, 1'b1, cfg_vec, 3'b000});
        @(negedge clk); irq_ack = 1; @(negedge clk); irq_ack = 0;
        chk("R7 tx after ack", {23'h0, irq_req, irq_vec}, {23'h0, 1'b1, cfg_vec, 3'b100});
        @(negedge clk); irq_ack = 1; @(negedge clk); irq_ack = 0;
        chk("R7 all acked", 32'(irq_req), 32'h0);
        rd(1, BASE); chk("R7 rx char", 32'(rv), 32'h0077);
        wr(0, 16'h0000, BASE);
        wr(2, 16'h0000, BASE);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule